// File: doc/BRIEF.md
# Parallel LCD write-cycle sequencer

This block drives the write side of an 8080-style parallel panel bus. It takes pixel words from a valid/ready stream and, for each word, produces one chip-select window containing a single write strobe with the data held on the bus. The timing inside the window is built from four phases: chip-select setup, write setup, write active and write hold. Each phase takes its length from a 4-bit count in a packed configuration word.

A frame is hsize × vsize words. A frame can be started in two ways. The first is a software command. The second is a rising edge on the panel's tearing-effect input, which can be gated by an enable and a mask. In hardware mode the tearing-effect edge starts a frame either only when an update has been requested, or on every edge. A repeated trigger can upset the panel, so the sequencer never restarts a frame that is running. When the frame-done interrupt is enabled, a trigger that arrives during a frame is dropped. When it is disabled, one such trigger is held and the next frame starts as soon as the current one ends. The end of a frame sets a sticky done flag, which is cleared by writing 1.

The timing fields and the frame size are captured when a frame starts. Software can therefore prepare the next setting while a frame is still being sent.

Top module: `lcd_wr_seq`

## Requirements
- R1: After reset, lcd_cs_no and lcd_wr_no are 1, pix_ready_o is 0 and done_o is 0.
- R2: The configuration word carries the interface enable in bit 0. It carries four counts: chip-select setup in bits 19:16, write setup in 15:12, write active in 11:8 and write hold in 7:4. Each phase lasts count+1 clocks, in the order chip-select setup, write setup, write active, write hold. Chip-select is low during all four phases. The write strobe is low only during write active. The strobe therefore first goes low on clock cs+ws+3 of the window, stays low for wa+1 clocks, and the window lasts cs+ws+wa+wh+4 clocks.
- R3: A word is taken when pix_valid_i and pix_ready_o are both high. pix_ready_o is high only while chip-select is high. lcd_data_o shows the taken word and is stable for the whole chip-select window. Words leave in the order they arrive.
- R4: A frame sends exactly hsize_i × vsize_i words. A frame of zero words ends at once and still sets done.
- R5: With bit 0 set and sw_mode_i=1, a one-cycle sw_trig_i starts a frame.
- R6: With bit 0 set, sw_mode_i=0, hw_en_i=1 and hw_mask_i=0, a rising edge of te_i starts a frame. If per_te_i=0, the edge must be preceded by an upd_i pulse, and it consumes that request. If per_te_i=1, every rising edge starts a frame.
- R7: Triggers are ignored when bit 0 is clear, when hw_mask_i=1 or hw_en_i=0 for edges of te_i, and when sw_trig_i arrives with sw_mode_i=0.
- R8: With irq_en_i=1, a trigger that arrives while a frame is running is dropped.
- R9: With irq_en_i=0, a trigger that arrives while a frame is running is held. The next frame starts right after the current one ends.
- R10: done_o sets at the end of each frame and stays set until done_clr_i=1.
- R11: The timing fields are captured at frame start. Changing cfg_i during a frame does not change that frame's cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Timing counts and interface enable |
| sw_mode_i | input | 1 | 1: software trigger mode, 0: tearing-effect mode |
| sw_trig_i | input | 1 | Software trigger command |
| hw_en_i | input | 1 | Enable tearing-effect triggering |
| hw_mask_i | input | 1 | Mask tearing-effect triggering |
| per_te_i | input | 1 | Trigger on every tearing-effect edge |
| te_i | input | 1 | Tearing-effect input from the panel |
| upd_i | input | 1 | Frame update request for tearing-effect mode |
| irq_en_i | input | 1 | Frame-done interrupt enabled |
| hsize_i | input | HSIZE_W | Words per line |
| vsize_i | input | VSIZE_W | Lines per frame |
| pix_data_i | input | DATA_W | Pixel word |
| pix_valid_i | input | 1 | Pixel word valid |
| pix_ready_o | output | 1 | Pixel word taken |
| lcd_cs_no | output | 1 | Chip-select, active low |
| lcd_wr_no | output | 1 | Write strobe, active low |
| lcd_data_o | output | DATA_W | Panel data bus |
| done_o | output | 1 | Sticky frame-done flag |
| done_clr_i | input | 1 | Clear done flag |

## Verification
The bench measures every chip-select window for several timing settings, including all-zero and all-maximum counts. An off-by-one in a phase counter would show up as a wrong window length or a wrong strobe offset. Swapped field positions would give the wrong phase lengths.

A second trigger is sent in the middle of a frame, once with the interrupt enabled and once with it disabled. A design without the guard would restart the frame or lose words. A design without the held trigger would send one frame instead of two.

The update-request consumption in tearing-effect mode is tested. A design that did not clear the request would start a frame on a bare second edge. The bench also changes cfg_i in the middle of a frame; a design that read it live would produce wrong window lengths. Finally, a zero-size frame checks that the sequencer does not hang waiting for a word.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;
  localparam int CNT_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_CSS, PH_WRS, PH_WRA, PH_WRH
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] css;
    logic [CNT_W-1:0] wrs;
    logic [CNT_W-1:0] wra;
    logic [CNT_W-1:0] wrh;
  } timing_t;

  localparam int CFG_EN_BIT = 0;
  localparam int CFG_WRH_LSB = 4;
  localparam int CFG_WRA_LSB = 8;
  localparam int CFG_WRS_LSB = 12;
  localparam int CFG_CSS_LSB = 16;
endpackage

// File: rtl/lcd_trig_ctrl.sv
module lcd_trig_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic if_en_i,
  input  logic sw_mode_i,
  input  logic sw_trig_i,
  input  logic hw_en_i,
  input  logic hw_mask_i,
  input  logic per_te_i,
  input  logic te_i,
  input  logic upd_i,
  input  logic irq_en_i,
  input  logic busy_i,
  output logic start_o
);
  logic te_q, upd_pend_q, hold_q;
  logic te_rise, hw_fire, sw_fire, req;

  assign te_rise = te_i & ~te_q;
  assign hw_fire = if_en_i & ~sw_mode_i & hw_en_i & ~hw_mask_i & te_rise &
                   (per_te_i | upd_pend_q);
  assign sw_fire = if_en_i & sw_mode_i & sw_trig_i;
  assign req     = sw_fire | hw_fire;
  assign start_o = ~busy_i & (req | hold_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      te_q       <= 1'b0;
      upd_pend_q <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      te_q <= te_i;
      if (upd_i) upd_pend_q <= 1'b1;
      else if (hw_fire && !per_te_i) upd_pend_q <= 1'b0;
      // busy with done irq off: keep one request for after the frame
      if (!if_en_i || start_o) hold_q <= 1'b0;
      else if (req && busy_i && !irq_en_i) hold_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lcd_word_cnt.sv
module lcd_word_cnt #(
  parameter int W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] total_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else if (load_i) rem_q <= total_i;
    else if (dec_i && rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  assign zero_o = (rem_q == '0);
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_wr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  timing_t           tim_i,
  input  logic              words_zero_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              take_o,
  output logic              busy_o,
  output logic              frame_end_o,
  output logic              cs_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] data_o
);
  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q;

  assign ready_o = (state_q == PH_LOAD) && !words_zero_i;
  assign take_o  = ready_o && valid_i;
  assign busy_o  = (state_q != PH_IDLE);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    frame_end_o = 1'b0;
    unique case (state_q)
      PH_IDLE: if (start_i) state_d = PH_LOAD;
      PH_LOAD: begin
        if (words_zero_i) begin
          state_d     = PH_IDLE;
          frame_end_o = 1'b1;
        end else if (valid_i) begin
          state_d = PH_CSS;
          cnt_d   = tim_i.css;
        end
      end
      PH_CSS: begin
        if (cnt_q == '0) begin state_d = PH_WRS; cnt_d = tim_i.wrs; end
        else cnt_d = cnt_q - 1'b1;
      end
      PH_WRS: begin
        if (cnt_q == '0) begin state_d = PH_WRA; cnt_d = tim_i.wra; end
        else cnt_d = cnt_q - 1'b1;
      end
      PH_WRA: begin
        if (cnt_q == '0) begin state_d = PH_WRH; cnt_d = tim_i.wrh; end
        else cnt_d = cnt_q - 1'b1;
      end
      PH_WRH: begin
        if (cnt_q == '0) state_d = PH_LOAD;
        else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (take_o) data_q <= data_i;
    end
  end

  assign cs_no  = !(state_q inside {PH_CSS, PH_WRS, PH_WRA, PH_WRH});
  assign wr_no  = (state_q != PH_WRA);
  assign data_o = data_q;
endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
  import lcd_wr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int HSIZE_W = 11,
  parameter int VSIZE_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        cfg_i,
  input  logic               sw_mode_i,
  input  logic               sw_trig_i,
  input  logic               hw_en_i,
  input  logic               hw_mask_i,
  input  logic               per_te_i,
  input  logic               te_i,
  input  logic               upd_i,
  input  logic               irq_en_i,
  input  logic [HSIZE_W-1:0] hsize_i,
  input  logic [VSIZE_W-1:0] vsize_i,
  input  logic [DATA_W-1:0]  pix_data_i,
  input  logic               pix_valid_i,
  output logic               pix_ready_o,
  output logic               lcd_cs_no,
  output logic               lcd_wr_no,
  output logic [DATA_W-1:0]  lcd_data_o,
  output logic               done_o,
  input  logic               done_clr_i
);
  localparam int TOT_W = HSIZE_W + VSIZE_W;

  logic         start, busy, take, frame_end, words_zero, done_q;
  timing_t      tim_q, tim_cfg;
  logic [TOT_W-1:0] total;

  assign tim_cfg.css = cfg_i[CFG_CSS_LSB +: CNT_W];
  assign tim_cfg.wrs = cfg_i[CFG_WRS_LSB +: CNT_W];
  assign tim_cfg.wra = cfg_i[CFG_WRA_LSB +: CNT_W];
  assign tim_cfg.wrh = cfg_i[CFG_WRH_LSB +: CNT_W];
  assign total = TOT_W'(hsize_i) * TOT_W'(vsize_i);

  lcd_trig_ctrl u_trig (
    .clk_i, .rst_ni,
    .if_en_i  (cfg_i[CFG_EN_BIT]),
    .sw_mode_i, .sw_trig_i, .hw_en_i, .hw_mask_i, .per_te_i,
    .te_i, .upd_i, .irq_en_i,
    .busy_i   (busy),
    .start_o  (start)
  );

  lcd_word_cnt #(.W(TOT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i  (start),
    .total_i (total),
    .dec_i   (take),
    .zero_o  (words_zero)
  );

  lcd_phase_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i      (start),
    .tim_i        (tim_q),
    .words_zero_i (words_zero),
    .valid_i      (pix_valid_i),
    .data_i       (pix_data_i),
    .ready_o      (pix_ready_o),
    .take_o       (take),
    .busy_o       (busy),
    .frame_end_o  (frame_end),
    .cs_no        (lcd_cs_no),
    .wr_no        (lcd_wr_no),
    .data_o       (lcd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (start) tim_q <= tim_cfg;
      if (frame_end) done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/lcd_wr_seq_chk.sv
module lcd_wr_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_no,
  input logic              wr_no,
  input logic [DATA_W-1:0] data,
  input logic              valid,
  input logic              ready,
  input logic              done,
  input logic              done_clr,
  input logic              busy
);
  // R2
  wr_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> !cs_no);
  // R2
  wr_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> $past(!cs_no));
  // R3
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(data));
  // R3
  cs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(valid && ready));
  // R3
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |-> cs_no);
  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(done) && !$past(done_clr)) |-> done);
  // R10
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $past(busy));
endmodule

bind lcd_wr_seq lcd_wr_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_no    (lcd_cs_no),
  .wr_no    (lcd_wr_no),
  .data     (lcd_data_o),
  .valid    (pix_valid_i),
  .ready    (pix_ready_o),
  .done     (done_o),
  .done_clr (done_clr_i),
  .busy     (busy)
);

// File: tb/sim_lcd_wr_seq.sv
`timescale 1ns/1ps
module sim_lcd_wr_seq;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] cfg = '0;
  logic sw_mode = 0, sw_trig = 0, hw_en = 0, hw_mask = 0, per_te = 0;
  logic te = 0, upd = 0, irq_en = 0, done_clr = 0, src_valid = 1;
  logic [10:0] hsize = '0, vsize = '0;
  logic [15:0] pix_data, lcd_data;
  logic pix_ready, cs_n, wr_n, done;
  logic [7:0] src_cnt = '0;

  assign pix_data = {8'h00, src_cnt ^ 8'h5A};

  lcd_wr_seq u0 (
    .clk_i(clk), .rst_ni, .cfg_i(cfg), .sw_mode_i(sw_mode), .sw_trig_i(sw_trig),
    .hw_en_i(hw_en), .hw_mask_i(hw_mask), .per_te_i(per_te), .te_i(te),
    .upd_i(upd), .irq_en_i(irq_en), .hsize_i(hsize), .vsize_i(vsize),
    .pix_data_i(pix_data), .pix_valid_i(src_valid), .pix_ready_o(pix_ready),
    .lcd_cs_no(cs_n), .lcd_wr_no(wr_n), .lcd_data_o(lcd_data),
    .done_o(done), .done_clr_i(done_clr)
  );

  always @(posedge clk) if (src_valid && pix_ready) src_cnt <= src_cnt + 8'd1;

  // window monitor
  int mon_words = 0, mon_err = 0, dat_err = 0;
  int cs_run = 0, wr_run = 0, lead = 0;
  int e_cs = 0, e_wr = 0, e_lead = 0;
  logic [7:0] mon_idx = '0;
  logic prev_cs = 1, prev_wr = 1;
  always @(negedge clk) if (rst_ni) begin
    if (prev_cs && !cs_n) begin mon_words++; cs_run = 1; wr_run = 0; lead = 0; end
    else if (!cs_n) cs_run++;
    if (!wr_n) begin
      if (prev_wr) begin
        lead = cs_run;
        if (lcd_data !== {8'h00, mon_idx ^ 8'h5A}) dat_err++;
        mon_idx++;
      end
      wr_run++;
    end
    if (!prev_cs && cs_n && (cs_run != e_cs || wr_run != e_wr || lead != e_lead)) mon_err++;
    prev_cs = cs_n;
    prev_wr = wr_n;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic sw_pulse();
    @(negedge clk) sw_trig = 1;
    @(negedge clk) sw_trig = 0;
  endtask

  task automatic te_pulse();
    @(negedge clk) te = 1;
    repeat (3) @(negedge clk);
    te = 0;
    @(negedge clk);
  endtask

  task automatic upd_pulse();
    @(negedge clk) upd = 1;
    @(negedge clk) upd = 0;
  endtask

  task automatic clr_done();
    @(negedge clk) done_clr = 1;
    @(negedge clk) done_clr = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic set_tim(input int cs, input int ws, input int wa, input int wh);
    cfg = {12'h000, 4'(cs), 4'(ws), 4'(wa), 4'(wh), 4'b0001};
    e_cs = cs + ws + wa + wh + 4;
    e_wr = wa + 1;
    e_lead = cs + ws + 3;
  endtask

  typedef struct packed {
    logic [3:0] cs, ws, wa, wh, h, v;
    logic [7:0] x_cs, x_wr, x_lead, x_words;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{4'd0,  4'd0,  4'd0,  4'd0,  4'd2, 4'd2, 8'd4,  8'd1,  8'd3,  8'd4},
    '{4'd1,  4'd2,  4'd1,  4'd0,  4'd3, 4'd1, 8'd8,  8'd2,  8'd6,  8'd3},
    '{4'd15, 4'd15, 4'd15, 4'd15, 4'd1, 4'd2, 8'd64, 8'd16, 8'd33, 8'd2},
    '{4'd0,  4'd3,  4'd0,  4'd2,  4'd4, 4'd1, 8'd9,  8'd1,  8'd6,  8'd4},
    '{4'd2,  4'd0,  4'd4,  4'd1,  4'd1, 4'd1, 8'd11, 8'd5,  8'd5,  8'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ok;
    int w0, e0, d0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    check(cs_n && wr_n, "R1 bus idle", {cs_n, wr_n}, 3);
    check(!pix_ready && !done, "R1 ready/done low", {pix_ready, done}, 0);

    // vector table: R2 R3 R4 R5 R10
    sw_mode = 1; irq_en = 1;
    for (int i = 0; i < 5; i++) begin
      cfg = {12'h000, VECS[i].cs, VECS[i].ws, VECS[i].wa, VECS[i].wh, 4'b0001};
      e_cs = int'(VECS[i].x_cs); e_wr = int'(VECS[i].x_wr); e_lead = int'(VECS[i].x_lead);
      hsize = 11'(VECS[i].h); vsize = 11'(VECS[i].v);
      clr_done();
      w0 = mon_words; e0 = mon_err; d0 = dat_err;
      sw_pulse();
      wait_done(ok);
      repeat (2) @(negedge clk);
      check(ok, "R10 done after frame", int'(ok), 1);
      check(mon_words - w0 == int'(VECS[i].x_words), "R4 word count", mon_words - w0, int'(VECS[i].x_words));
      check(mon_err == e0, "R2 window timing", mon_err - e0, 0);
      check(dat_err == d0, "R3 data order", dat_err - d0, 0);
    end

    // R10 sticky then clear
    repeat (5) @(negedge clk);
    check(done, "R10 sticky", int'(done), 1);
    clr_done();
    check(!done, "R10 clear", int'(done), 0);

    // R4 zero size
    hsize = 0; vsize = 5;
    w0 = mon_words;
    sw_pulse();
    wait_done(ok);
    check(ok && mon_words == w0, "R4 zero frame", mon_words - w0, 0);
    clr_done();

    // R7 disabled interface, sw trig outside sw mode
    set_tim(1, 1, 1, 1); hsize = 2; vsize = 1;
    cfg[0] = 0;
    w0 = mon_words;
    sw_pulse();
    repeat (60) @(negedge clk);
    check(mon_words == w0 && !done, "R7 enable clear", mon_words - w0, 0);
    cfg[0] = 1; sw_mode = 0;
    sw_pulse();
    repeat (60) @(negedge clk);
    check(mon_words == w0 && !done, "R7 sw trig in hw mode", mon_words - w0, 0);

    // R6 hw trigger
    hw_en = 1; hw_mask = 0; per_te = 0;
    te_pulse();
    repeat (60) @(negedge clk);
    check(mon_words == w0, "R6 te without update", mon_words - w0, 0);
    hw_mask = 1;
    upd_pulse();
    te_pulse();
    repeat (60) @(negedge clk);
    check(mon_words == w0, "R7 masked te", mon_words - w0, 0);
    hw_mask = 0;
    te_pulse();
    wait_done(ok);
    check(ok && mon_words - w0 == 2, "R6 te with update", mon_words - w0, 2);
    clr_done();
    w0 = mon_words;
    te_pulse();
    repeat (60) @(negedge clk);
    check(mon_words == w0, "R6 update consumed", mon_words - w0, 0);
    per_te = 1;
    te_pulse();
    wait_done(ok);
    clr_done();
    te_pulse();
    wait_done(ok);
    check(ok && mon_words - w0 == 4, "R6 every te", mon_words - w0, 4);
    clr_done();
    hw_en = 0; per_te = 0; sw_mode = 1;

    // R8 drop during frame
    set_tim(2, 2, 2, 2); hsize = 4; vsize = 1; irq_en = 1;
    w0 = mon_words;
    sw_pulse();
    repeat (10) @(negedge clk);
    sw_pulse();
    wait_done(ok);
    repeat (120) @(negedge clk);
    check(ok && mon_words - w0 == 4, "R8 retrigger dropped", mon_words - w0, 4);
    clr_done();

    // R9 hold during frame
    irq_en = 0;
    w0 = mon_words;
    sw_pulse();
    repeat (10) @(negedge clk);
    sw_pulse();
    wait_done(ok);
    repeat (200) @(negedge clk);
    check(ok && mon_words - w0 == 8, "R9 retrigger held", mon_words - w0, 8);
    clr_done();
    irq_en = 1;

    // R11 config captured at start
    set_tim(1, 1, 1, 1); hsize = 3; vsize = 1;
    w0 = mon_words; e0 = mon_err;
    sw_pulse();
    repeat (3) @(negedge clk);
    cfg = {12'h000, 16'h5555, 4'b0001};
    wait_done(ok);
    repeat (2) @(negedge clk);
    check(ok && mon_words - w0 == 3, "R11 words", mon_words - w0, 3);
    check(mon_err == e0, "R11 timing held", mon_err - e0, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule